// File: doc/BRIEF.md
# BCD Calendar Counter with 12/24-Hour Mode

This block is the timekeeping core of a real-time clock. It holds eight packed-BCD registers: seconds, minutes, hours, day of week, date, month, two-digit year and century. The registers advance once per single-cycle `tick` pulse, which is the 1 Hz pulse from an upstream divider. Carries ripple from seconds up to the century in the same cycle. The hour register carries its own format bit. When that bit is set, the hour counts 1 to 12 and a PM flag is kept. When it is clear, the hour counts 00 to 23.

A host changes the time by presenting all eight fields on `load_fields` and pulsing `load`. All eight fields are replaced together, and the next tick counts on from the loaded value. A host reads the time by pulsing `snap`. A 64-bit holding register then captures every field in the same cycle. A read of that register therefore cannot mix values from before and after a carry, and the counters keep running while the host reads it. Load and snapshot are ordered against the tick so that neither one collides with an increment.

Field layout on both 64-bit buses: bits [7:0] seconds, [15:8] minutes, [23:16] hour, [31:24] day of week, [39:32] date, [47:40] month, [55:48] year, [63:56] century.

Top module: `rtc_calendar_core`

## Requirements
- R1: Synchronous active-high `rst` sets the counters, and the snapshot register, to 00:00:00 in 24-hour mode with hour byte 00h, day of week 01h, date 01h, month 01h, year 00h and century 19h.
- R2: Seconds and minutes count in BCD from 00 to 59 (09 is followed by 10). A tick at 59 seconds wraps seconds to 00 and advances minutes, and minutes at 59 wrap to 00 and advance the hour.
- R3: With hour bit 7 clear (24-hour mode), the hour counts 00h to 23h, and bit 5 is the tens bit that is set for hours 20 to 23. Advancing from 23 gives 00 and advances the day.
- R4: With hour bit 7 set (12-hour mode), bits 4:0 count 1 to 12 in BCD and bit 5 is set for PM. 11 advances to 12 and toggles bit 5, and 12 advances to 01 with bit 5 unchanged. The day advances when 11 PM becomes 12 AM. Examples: 91h→B2h, B2h→A1h, B1h→92h.
- R5: Each day advance moves the day of week up by one, and 7 wraps to 1.
- R6: The date wraps to 01 and the month advances after 30 in months 04h, 06h, 09h and 11h, and after 31 in the other months except February.
- R7: February ends at 29 when the two-digit year is divisible by 4 (year 00 included), and at 28 otherwise.
- R8: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and advances the century in BCD.
- R9: A `load` pulse replaces all eight fields with `load_fields` at the next clock edge. A tick in the same cycle is discarded.
- R10: A `snap` pulse captures all fields at the next clock edge, as they stand after that cycle's update, so a tick in the same cycle is included. Without `snap`, `snap_fields` holds its value while the counters advance.
- R11: In a cycle with neither `tick` nor `load`, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, once per second |
| load | input | 1 | One-cycle pulse: take `load_fields` as the new time |
| load_fields | input | 64 | New time, packed BCD, in the field layout above |
| snap | input | 1 | One-cycle pulse: capture the current time |
| snap_fields | output | 64 | Captured time, packed BCD, in the field layout above |

## Verification
The counters can only be observed through the snapshot register, so a wrong internal state shows up in the first snapshot taken after the fault, one cycle after `snap`. The field that is wrong points to the cause. A bad month-length or leap decode shows only at an end-of-month rollover. A mishandled 12-hour step shows as a wrong hour byte or PM bit right after the 11 or 12 boundary. A carry that is lost or doubled corrupts every higher field in that same snapshot. The bench therefore loads times just before each boundary, ticks once and snapshots, so any such error appears within three cycles of the load.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int FIELD_W = 8;

    typedef struct packed {
        logic [FIELD_W-1:0] cent;
        logic [FIELD_W-1:0] year;
        logic [FIELD_W-1:0] month;
        logic [FIELD_W-1:0] date;
        logic [FIELD_W-1:0] dow;
        logic [FIELD_W-1:0] hour;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] sec;
    } cal_t;

    localparam int CAL_W = $bits(cal_t);

    localparam logic [7:0] BCD_59 = 8'h59;
    localparam logic [7:0] BCD_99 = 8'h99;
    localparam logic [7:0] BCD_12 = 8'h12;
    localparam logic [7:0] DOW_LAST = 8'h07;

    // Two-digit BCD increment; the caller handles the wrap.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic is_leap(input logic [7:0] y);
        logic [6:0] bin;
        bin = {3'b000, y[7:4]} * 7'd10 + {3'b000, y[3:0]};
        return bin[1:0] == 2'b00;
    endfunction

    // Last date of the month, in BCD.
    function automatic logic [7:0] last_date(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);
    logic       c_min, c_hour, c_day, c_mon, c_year, c_cent;
    logic [4:0] hr12;
    logic       pm;

    always_comb begin
        nxt    = cur;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        c_cent = 1'b0;
        hr12   = cur.hour[4:0];
        pm     = cur.hour[5];

        if (cur.sec == BCD_59) begin
            nxt.sec = 8'h00;
            c_min   = 1'b1;
        end else begin
            nxt.sec = bcd_inc(cur.sec);
        end

        if (c_min) begin
            if (cur.min == BCD_59) begin
                nxt.min = 8'h00;
                c_hour  = 1'b1;
            end else begin
                nxt.min = bcd_inc(cur.min);
            end
        end

        if (c_hour) begin
            if (cur.hour[7]) begin
                // 12-hour format: bits 4:0 BCD 1..12, bit 5 PM
                if (cur.hour[4:0] == 5'h12) begin
                    hr12 = 5'h01;
                end else if (cur.hour[4:0] == 5'h11) begin
                    hr12  = 5'h12;
                    pm    = ~cur.hour[5];
                    c_day = cur.hour[5];
                end else begin
                    hr12 = bcd_inc({3'b000, cur.hour[4:0]}) [4:0];
                end
                nxt.hour = {1'b1, 1'b0, pm, hr12};
            end else begin
                if (cur.hour[5:0] == 6'h23) begin
                    nxt.hour = 8'h00;
                    c_day    = 1'b1;
                end else begin
                    nxt.hour = {2'b00, bcd_inc({2'b00, cur.hour[5:0]}) [5:0]};
                end
            end
        end

        if (c_day) begin
            nxt.dow = (cur.dow == DOW_LAST) ? 8'h01 : bcd_inc(cur.dow);
            if (cur.date == last_date(cur.month, cur.year)) begin
                nxt.date = 8'h01;
                c_mon    = 1'b1;
            end else begin
                nxt.date = bcd_inc(cur.date);
            end
        end

        if (c_mon) begin
            if (cur.month == BCD_12) begin
                nxt.month = 8'h01;
                c_year    = 1'b1;
            end else begin
                nxt.month = bcd_inc(cur.month);
            end
        end

        if (c_year) begin
            if (cur.year == BCD_99) begin
                nxt.year = 8'h00;
                c_cent   = 1'b1;
            end else begin
                nxt.year = bcd_inc(cur.year);
            end
        end

        if (c_cent)
            nxt.cent = (cur.cent == BCD_99) ? 8'h00 : bcd_inc(cur.cent);
    end
endmodule

// File: rtl/rtc_snap_latch.sv
module rtc_snap_latch
    import rtc_pkg::*;
#(
    parameter cal_t RESET_VAL = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  cal_t src,
    output cal_t held
);
    always_ff @(posedge clk) begin
        if (rst)
            held <= RESET_VAL;
        else if (capture)
            held <= src;
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter logic [7:0] CENTURY_INIT = 8'h19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CAL_W-1:0] load_fields,
    input  logic             snap,
    output logic [CAL_W-1:0] snap_fields
);
    localparam cal_t RESET_TIME = '{cent: CENTURY_INIT, year: 8'h00, month: 8'h01,
                                    date: 8'h01, dow: 8'h01, hour: 8'h00,
                                    min: 8'h00, sec: 8'h00};

    cal_t cur, advanced, cur_next, held;

    rtc_advance u_adv (
        .cur (cur),
        .nxt (advanced)
    );

    // Load has priority over a coincident tick.
    always_comb begin
        if (load)
            cur_next = cal_t'(load_fields);
        else if (tick)
            cur_next = advanced;
        else
            cur_next = cur;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= RESET_TIME;
        else
            cur <= cur_next;
    end

    // Snapshot takes the post-update value, so a same-cycle tick is included.
    rtc_snap_latch #(.RESET_VAL(RESET_TIME)) u_snap (
        .clk     (clk),
        .rst     (rst),
        .capture (snap),
        .src     (cur_next),
        .held    (held)
    );

    assign snap_fields = held;

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> cur == cal_t'($past(load_fields)));

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cur));

    assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cur.sec == 8'h59) |=> cur.sec == 8'h00);

    assert_pm_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cur.hour[7] && cur.hour[4:0] == 5'h11 &&
         cur.min == 8'h59 && cur.sec == 8'h59)
        |=> cur.hour[5] != $past(cur.hour[5]));

    assert_dow_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cur.dow == 8'h07 && cur.hour == 8'h23 &&
         cur.min == 8'h59 && cur.sec == 8'h59) |=> cur.dow == 8'h01);

    assert_snap_match_R10: assert property (@(posedge clk) disable iff (rst)
        snap |=> snap_fields == CAL_W'(cur));

    assert_snap_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !snap |=> $stable(snap_fields));
endmodule

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        load = 1'b0;
    logic        snap = 1'b0;
    logic [63:0] load_fields = '0;
    logic [63:0] snap_fields;
    logic        snap_d = 1'b0;

    int checks = 0;
    int failures = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_calendar_core u0 (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .load        (load),
        .load_fields (load_fields),
        .snap        (snap),
        .snap_fields (snap_fields)
    );

    function automatic logic [63:0] pk(input logic [7:0] c, y, mo, d, w, h, mi, s);
        return {c, y, mo, d, w, h, mi, s};
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic t, input logic l, input logic s, input logic [63:0] v);
        tick = t; load = l; snap = s; load_fields = v;
        @(negedge clk);
        tick = 1'b0; load = 1'b0; snap = 1'b0;
    endtask

    task automatic expect_snap(input logic [63:0] exp, input string tag, input logic with_tick);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        pulse(with_tick, 1'b0, 1'b1, '0);
    endtask

    // Load a time, tick once, then snapshot and compare.
    task automatic step_case(input logic [63:0] start, input logic [63:0] exp, input string tag);
        pulse(1'b0, 1'b1, 1'b0, start);
        pulse(1'b1, 1'b0, 1'b0, '0);
        expect_snap(exp, tag, 1'b0);
    endtask

    // Monitor: the result appears one edge after the snap strobe.
    always @(posedge clk) snap_d <= snap;

    always @(negedge clk) begin
        if (snap_d && !rst) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R10 unexpected snapshot actual=%h expected=none", snap_fields);
            end else begin
                check(snap_fields, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state, directly and through a snapshot
        check(snap_fields, pk(8'h19, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), "R1 reset snapshot register");
        expect_snap(pk(8'h19, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), "R1 reset counters", 1'b0);

        // R2 seconds BCD digit carry and minute carry
        step_case(pk(8'h20, 8'h10, 8'h01, 8'h01, 8'h01, 8'h12, 8'h34, 8'h09),
                  pk(8'h20, 8'h10, 8'h01, 8'h01, 8'h01, 8'h12, 8'h34, 8'h10), "R2 seconds 09->10");
        step_case(pk(8'h20, 8'h10, 8'h01, 8'h01, 8'h01, 8'h12, 8'h34, 8'h59),
                  pk(8'h20, 8'h10, 8'h01, 8'h01, 8'h01, 8'h12, 8'h35, 8'h00), "R2 minute carry");

        // R3 R5 R6 R8: full rollover into the next century
        pulse(1'b0, 1'b1, 1'b0, pk(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58));
        pulse(1'b1, 1'b0, 1'b0, '0);
        expect_snap(pk(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59), "R2 plain tick", 1'b0);
        pulse(1'b1, 1'b0, 1'b0, '0);
        expect_snap(pk(8'h21, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), "R3 R5 R8 century rollover", 1'b0);

        // R11 idle cycles change nothing
        repeat (5) @(negedge clk);
        expect_snap(pk(8'h21, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), "R11 idle hold", 1'b0);

        // R4 12-hour steps
        step_case(pk(8'h20, 8'h10, 8'h03, 8'h05, 8'h02, 8'h91, 8'h59, 8'h59),
                  pk(8'h20, 8'h10, 8'h03, 8'h05, 8'h02, 8'hB2, 8'h00, 8'h00), "R4 11AM->12PM");
        step_case(pk(8'h20, 8'h10, 8'h03, 8'h05, 8'h02, 8'hB2, 8'h59, 8'h59),
                  pk(8'h20, 8'h10, 8'h03, 8'h05, 8'h02, 8'hA1, 8'h00, 8'h00), "R4 12PM->1PM");
        step_case(pk(8'h20, 8'h10, 8'h06, 8'h15, 8'h03, 8'hB1, 8'h59, 8'h59),
                  pk(8'h20, 8'h10, 8'h06, 8'h16, 8'h04, 8'h92, 8'h00, 8'h00), "R4 R5 11PM->12AM day advance");

        // R6 month lengths
        step_case(pk(8'h20, 8'h10, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59),
                  pk(8'h20, 8'h10, 8'h05, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00), "R6 30-day month end");
        step_case(pk(8'h20, 8'h10, 8'h05, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59),
                  pk(8'h20, 8'h10, 8'h05, 8'h31, 8'h02, 8'h00, 8'h00, 8'h00), "R6 31-day month 30->31");

        // R7 February and leap years
        step_case(pk(8'h20, 8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59),
                  pk(8'h20, 8'h24, 8'h02, 8'h29, 8'h02, 8'h00, 8'h00, 8'h00), "R7 leap Feb 28->29");
        step_case(pk(8'h20, 8'h24, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59),
                  pk(8'h20, 8'h24, 8'h03, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00), "R7 leap Feb 29->Mar");
        step_case(pk(8'h20, 8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59),
                  pk(8'h20, 8'h23, 8'h03, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00), "R7 common Feb 28->Mar");
        step_case(pk(8'h20, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59),
                  pk(8'h20, 8'h00, 8'h02, 8'h29, 8'h02, 8'h00, 8'h00, 8'h00), "R7 year 00 is leap");

        // R8 year-only rollover keeps century digits in BCD
        step_case(pk(8'h19, 8'h99, 8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59),
                  pk(8'h20, 8'h00, 8'h01, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00), "R8 century 19->20");

        // R9 load beats a coincident tick
        pulse(1'b1, 1'b1, 1'b0, pk(8'h20, 8'h11, 8'h01, 8'h01, 8'h03, 8'h10, 8'h20, 8'h30));
        expect_snap(pk(8'h20, 8'h11, 8'h01, 8'h01, 8'h03, 8'h10, 8'h20, 8'h30), "R9 load wins over tick", 1'b0);

        // R10 snapshot with a coincident tick, then holding while counting
        expect_snap(pk(8'h20, 8'h11, 8'h01, 8'h01, 8'h03, 8'h10, 8'h20, 8'h31), "R10 snap includes tick", 1'b1);
        repeat (3) pulse(1'b1, 1'b0, 1'b0, '0);
        check(snap_fields, pk(8'h20, 8'h11, 8'h01, 8'h01, 8'h03, 8'h10, 8'h20, 8'h31), "R10 snapshot held");
        expect_snap(pk(8'h20, 8'h11, 8'h01, 8'h01, 8'h03, 8'h10, 8'h20, 8'h34), "R10 counters kept running", 1'b0);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL R10 pending snapshots actual=%0d expected=0", exp_q.size());
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule